// File: doc/BRIEF.md
# Vector Bitwise Select Unit

This block serves a 256-bit SIMD register file with 32 entries. It takes a 32-bit instruction word and decodes two per-bit select forms. The register form picks every result bit from one of two source registers, steered by a third register used as a mask. The immediate form uses the current destination value as the mask. Where a mask bit is 1 it takes the bit from an 8-bit constant copied into every byte, and where it is 0 it takes the bit from a source register.

The decoder drives the read-port indices combinationally from the instruction word. The register file returns the operand data in the same cycle. A single register stage then presents the write enable, the destination index and the 256-bit result on the write port one clock later. A word that matches neither encoding produces no write.

Top module: `vbsel_unit`

## Requirements
- R1: After reset is released, and before any instruction is accepted, `wr_en` is 0, `wr_idx` is 0 and `wr_data` is 0.
- R2: Register form: bits [31:20] equal 12'b0000_1101_0010. Bits [19:15] give the mask register, [14:10] the alternate register, [9:5] the source register and [4:0] the destination. Each result bit equals the alternate bit where the mask bit is 1 and the source bit where it is 0.
- R3: Immediate form: bits [31:18] equal 14'b0111_0111_1100_01. Bits [17:10] hold the 8-bit constant, [9:5] the source register and [4:0] the destination. In every one of the 32 bytes, the result is (NOT old_dest AND source) OR (old_dest AND constant).
- R4: Read indices follow the word in the same cycle. The register form drives `mask_idx`, `alt_idx`, `src_idx` and `dst_rd_idx` from its four fields. The immediate form drives `src_idx` and `dst_rd_idx` and holds `mask_idx` and `alt_idx` at 0. Any other word holds all four indices at 0.
- R5: A valid word that matches neither encoding gives `wr_en`=0, `wr_idx`=0 and `wr_data`=0 in the following cycle.
- R6: In a cycle with `instr_valid` low, the next cycle shows `wr_en`=0, `wr_idx`=0 and `wr_data`=0.
- R7: A valid decoded instruction writes exactly one cycle after it is presented: `wr_en`=1, with `wr_idx` equal to its bits [4:0]. Instructions on consecutive cycles give writes on consecutive cycles.
- R8: Corner cases. A register-form mask of all ones yields the alternate operand, and a mask of all zeros yields the source operand. An immediate-form old destination of all ones yields the constant copied into all 32 bytes, and one of all zeros yields the source operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word is present this cycle |
| instr | input | 32 | Instruction word |
| mask_idx | output | 5 | Read index of the mask register (register form) |
| alt_idx | output | 5 | Read index of the register chosen where the mask is 1 |
| src_idx | output | 5 | Read index of the register chosen where the mask is 0 |
| dst_rd_idx | output | 5 | Read index of the destination's current value |
| mask_data | input | 256 | Data read at mask_idx |
| alt_data | input | 256 | Data read at alt_idx |
| src_data | input | 256 | Data read at src_idx |
| dst_old_data | input | 256 | Data read at dst_rd_idx |
| wr_en | output | 1 | Write enable for the destination register |
| wr_idx | output | 5 | Destination register index to write |
| wr_data | output | 256 | Result to write |

## Verification
A fault in the decoder shows up in the same cycle as wrong read indices. It shows up one clock later as a write that is missing or spurious, or that lands at the wrong index. A fault in one byte lane corrupts only that lane's eight bits of `wr_data`, and only in the cycle after the instruction. The all-ones and all-zeros masks expose a select that is inverted or stuck. Random operands expose a wrong mix of bits inside a byte. Since there is just one register stage, every error is visible within one clock of its cause and cannot hide in later state.

// File: rtl/vbsel_pkg.sv
package vbsel_pkg;
  localparam int VEC_W   = 256;
  localparam int IDX_W   = 5;
  localparam int LANE_W  = 8;
  localparam int INSTR_W = 32;
  localparam int LANES   = VEC_W / LANE_W;

  localparam int REG_OPC_W = 12;
  localparam int IMM_OPC_W = 14;
  localparam logic [REG_OPC_W-1:0] REG_OPC = 12'b0000_1101_0010;
  localparam logic [IMM_OPC_W-1:0] IMM_OPC = 14'b0111_0111_1100_01;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_REG  = 2'd1,
    OP_IMM  = 2'd2
  } op_kind_e;

  typedef struct packed {
    op_kind_e          kind;
    logic [IDX_W-1:0]  mask_idx;
    logic [IDX_W-1:0]  alt_idx;
    logic [IDX_W-1:0]  src_idx;
    logic [IDX_W-1:0]  dst_idx;
    logic [LANE_W-1:0] imm;
  } dec_t;

  // Per-bit choice: 'one' where sel is 1, 'zero' where sel is 0.
  function automatic logic [LANE_W-1:0] pick_bits(
    input logic [LANE_W-1:0] sel,
    input logic [LANE_W-1:0] one,
    input logic [LANE_W-1:0] zero
  );
    return (one & sel) | (zero & ~sel);
  endfunction
endpackage

// File: rtl/vbsel_decode.sv
module vbsel_decode
  import vbsel_pkg::*;
#(
  parameter int IW = INSTR_W
) (
  input  logic [IW-1:0] instr,
  output dec_t          dec
);
  logic hit_reg;
  logic hit_imm;

  assign hit_reg = (instr[IW-1 -: REG_OPC_W] == REG_OPC);
  assign hit_imm = (instr[IW-1 -: IMM_OPC_W] == IMM_OPC);

  always_comb begin
    dec = '0;
    dec.kind = OP_NONE;
    if (hit_reg) begin
      dec.kind     = OP_REG;
      dec.mask_idx = instr[3*IDX_W +: IDX_W];
      dec.alt_idx  = instr[2*IDX_W +: IDX_W];
      dec.src_idx  = instr[IDX_W +: IDX_W];
      dec.dst_idx  = instr[0 +: IDX_W];
    end else if (hit_imm) begin
      dec.kind    = OP_IMM;
      dec.imm     = instr[2*IDX_W +: LANE_W];
      dec.src_idx = instr[IDX_W +: IDX_W];
      dec.dst_idx = instr[0 +: IDX_W];
    end
  end
endmodule

// File: rtl/vbsel_lane.sv
module vbsel_lane
  import vbsel_pkg::*;
(
  input  op_kind_e          kind,
  input  logic [LANE_W-1:0] imm,
  input  logic [LANE_W-1:0] mask_b,
  input  logic [LANE_W-1:0] alt_b,
  input  logic [LANE_W-1:0] src_b,
  input  logic [LANE_W-1:0] old_b,
  output logic [LANE_W-1:0] res_b
);
  logic [LANE_W-1:0] reg_res;
  logic [LANE_W-1:0] imm_res;

  assign reg_res = pick_bits(mask_b, alt_b, src_b);
  assign imm_res = pick_bits(old_b, imm, src_b);

  always_comb begin
    unique case (kind)
      OP_REG:  res_b = reg_res;
      OP_IMM:  res_b = imm_res;
      default: res_b = '0;
    endcase
  end
endmodule

// File: rtl/vbsel_datapath.sv
module vbsel_datapath
  import vbsel_pkg::*;
#(
  parameter int W = VEC_W
) (
  input  op_kind_e          kind,
  input  logic [LANE_W-1:0] imm,
  input  logic [W-1:0]      mask_v,
  input  logic [W-1:0]      alt_v,
  input  logic [W-1:0]      src_v,
  input  logic [W-1:0]      old_v,
  output logic [W-1:0]      res_v
);
  localparam int NL = W / LANE_W;

  for (genvar g = 0; g < NL; g++) begin : g_lane
    vbsel_lane u_lane (
      .kind   (kind),
      .imm    (imm),
      .mask_b (mask_v[g*LANE_W +: LANE_W]),
      .alt_b  (alt_v[g*LANE_W +: LANE_W]),
      .src_b  (src_v[g*LANE_W +: LANE_W]),
      .old_b  (old_v[g*LANE_W +: LANE_W]),
      .res_b  (res_v[g*LANE_W +: LANE_W])
    );
  end
endmodule

// File: rtl/vbsel_unit.sv
module vbsel_unit
  import vbsel_pkg::*;
#(
  parameter int W  = VEC_W,
  parameter int IW = INSTR_W,
  parameter int XW = IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          instr_valid,
  input  logic [IW-1:0] instr,
  output logic [XW-1:0] mask_idx,
  output logic [XW-1:0] alt_idx,
  output logic [XW-1:0] src_idx,
  output logic [XW-1:0] dst_rd_idx,
  input  logic [W-1:0]  mask_data,
  input  logic [W-1:0]  alt_data,
  input  logic [W-1:0]  src_data,
  input  logic [W-1:0]  dst_old_data,
  output logic          wr_en,
  output logic [XW-1:0] wr_idx,
  output logic [W-1:0]  wr_data
);
  dec_t         dec;
  logic [W-1:0] sel_result;
  logic         fire;
  logic         drop_word;

  vbsel_decode #(.IW(IW)) u_dec (
    .instr (instr),
    .dec   (dec)
  );

  assign mask_idx   = dec.mask_idx;
  assign alt_idx    = dec.alt_idx;
  assign src_idx    = dec.src_idx;
  assign dst_rd_idx = dec.dst_idx;

  vbsel_datapath #(.W(W)) u_dp (
    .kind   (dec.kind),
    .imm    (dec.imm),
    .mask_v (mask_data),
    .alt_v  (alt_data),
    .src_v  (src_data),
    .old_v  (dst_old_data),
    .res_v  (sel_result)
  );

  // Named events for the checks below.
  assign fire      = instr_valid && (dec.kind != OP_NONE);
  assign drop_word = instr_valid && (dec.kind == OP_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      wr_en   <= fire;
      wr_idx  <= fire ? dec.dst_idx : '0;
      wr_data <= fire ? sel_result : '0;
    end
  end

  // R5
  no_write_on_unknown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_word |=> (!wr_en && wr_data == '0));

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |=> (!wr_en && wr_idx == '0 && wr_data == '0));

  // R7
  write_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (wr_en && wr_idx == $past(instr[XW-1:0])));

  // R8
  full_mask_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && instr[IW-1 -: REG_OPC_W] == REG_OPC && (&mask_data))
      |=> wr_data == $past(alt_data));

  // R8
  empty_mask_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && instr[IW-1 -: REG_OPC_W] == REG_OPC && mask_data == '0)
      |=> wr_data == $past(src_data));

  // R4
  imm_idx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[IW-1 -: IMM_OPC_W] == IMM_OPC) |-> (mask_idx == '0 && alt_idx == '0));
endmodule

// File: tb/vbsel_unit_tb_top.sv
module vbsel_unit_tb_top;
  localparam int W = 256;

  typedef struct {
    logic         en;
    logic [4:0]   idx;
    logic [W-1:0] data;
    string        tag;
  } item_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         instr_valid = 1'b0;
  logic [31:0]  instr = '0;
  logic [4:0]   mask_idx, alt_idx, src_idx, dst_rd_idx;
  logic [W-1:0] mask_data = '0, alt_data = '0, src_data = '0, dst_old_data = '0;
  logic         wr_en;
  logic [4:0]   wr_idx;
  logic [W-1:0] wr_data;

  int errors = 0;
  int checks = 0;
  bit run_mon = 1'b0;
  item_t sb[$];

  always #4 clk = ~clk;

  vbsel_unit dut_i (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
    .mask_idx(mask_idx), .alt_idx(alt_idx), .src_idx(src_idx),
    .dst_rd_idx(dst_rd_idx), .mask_data(mask_data), .alt_data(alt_data),
    .src_data(src_data), .dst_old_data(dst_old_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  function automatic logic [W-1:0] rnd256();
    logic [W-1:0] v;
    for (int i = 0; i < W/32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  // Reference written bit by bit / byte by byte from R2 and R3.
  function automatic logic [W-1:0] ref_reg(logic [W-1:0] m, logic [W-1:0] k, logic [W-1:0] j);
    logic [W-1:0] r;
    for (int b = 0; b < W; b++) r[b] = m[b] ? k[b] : j[b];
    return r;
  endfunction

  function automatic logic [W-1:0] ref_imm(logic [W-1:0] d, logic [W-1:0] j, logic [7:0] c);
    logic [W-1:0] r;
    for (int y = 0; y < W/8; y++)
      r[y*8 +: 8] = (~d[y*8 +: 8] & j[y*8 +: 8]) | (d[y*8 +: 8] & c);
    return r;
  endfunction

  task automatic check_idx(string tag, logic [19:0] got, logic [19:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s read indices got=%h expected=%h", tag, got, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus at a falling edge and pushes the expectation.
  task automatic drive(logic v, logic [31:0] w, logic [W-1:0] m, logic [W-1:0] k,
                       logic [W-1:0] j, logic [W-1:0] d, string tag);
    item_t it;
    logic [19:0] eidx;
    @(negedge clk);
    instr_valid = v; instr = w;
    mask_data = m; alt_data = k; src_data = j; dst_old_data = d;
    it.en = 1'b0; it.idx = '0; it.data = '0; it.tag = tag;
    eidx = '0;
    if (w[31:20] == 12'b0000_1101_0010) begin
      eidx = {w[19:15], w[14:10], w[9:5], w[4:0]};
      if (v) begin it.en = 1'b1; it.idx = w[4:0]; it.data = ref_reg(m, k, j); end
    end else if (w[31:18] == 14'b0111_0111_1100_01) begin
      eidx = {10'd0, w[9:5], w[4:0]};
      if (v) begin it.en = 1'b1; it.idx = w[4:0]; it.data = ref_imm(d, j, w[17:10]); end
    end
    sb.push_back(it);
    #1;
    check_idx("R4", {mask_idx, alt_idx, src_idx, dst_rd_idx}, eidx);
  endtask

  function automatic logic [31:0] reg_word(logic [4:0] a, logic [4:0] k, logic [4:0] j, logic [4:0] d);
    return {12'b0000_1101_0010, a, k, j, d};
  endfunction

  function automatic logic [31:0] imm_word(logic [7:0] c, logic [4:0] j, logic [4:0] d);
    return {14'b0111_0111_1100_01, c, j, d};
  endfunction

  // Monitor: pops one expectation per clock, sampled 1 ns after the edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (run_mon && sb.size() > 0) begin
        item_t e;
        e = sb.pop_front();
        checks++;
        if (wr_en !== e.en || wr_idx !== e.idx || wr_data !== e.data) begin
          errors++;
          $display("FAIL %s en/idx/data got=%b/%0d/%h expected=%b/%0d/%h",
                   e.tag, wr_en, wr_idx, wr_data, e.en, e.idx, e.data);
        end
      end
    end
  end

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [W-1:0] k, j, d;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R1
    checks++;
    if (wr_en !== 1'b0 || wr_idx !== '0 || wr_data !== '0) begin
      errors++;
      $display("FAIL R1 reset outputs got=%b/%0d/%h expected=0/0/0", wr_en, wr_idx, wr_data);
    end
    run_mon = 1'b1;

    // R8 corner masks, register form
    k = rnd256(); j = rnd256();
    drive(1, reg_word(5'd1, 5'd2, 5'd3, 5'd4), {W{1'b1}}, k, j, rnd256(), "R8");
    drive(1, reg_word(5'd31, 5'd0, 5'd17, 5'd9), '0, k, j, rnd256(), "R8");
    // R8 corner old-dest, immediate form
    drive(1, imm_word(8'hA5, 5'd6, 5'd7), '0, '0, j, {W{1'b1}}, "R8");
    drive(1, imm_word(8'h3C, 5'd8, 5'd30), '0, '0, j, '0, "R8");

    // R2 random register form, back to back (R7)
    for (int n = 0; n < 24; n++)
      drive(1, reg_word(5'($urandom), 5'($urandom), 5'($urandom), 5'($urandom)),
            rnd256(), rnd256(), rnd256(), rnd256(), "R2");
    // R3 random immediate form
    for (int n = 0; n < 24; n++)
      drive(1, imm_word(8'($urandom), 5'($urandom), 5'($urandom)),
            rnd256(), rnd256(), rnd256(), rnd256(), "R3");
    // R7 alternating forms on consecutive cycles
    for (int n = 0; n < 8; n++) begin
      drive(1, reg_word(5'(n), 5'(n+1), 5'(n+2), 5'(n+3)),
            rnd256(), rnd256(), rnd256(), rnd256(), "R7");
      drive(1, imm_word(8'(n*37), 5'(n+4), 5'(31-n)),
            rnd256(), rnd256(), rnd256(), rnd256(), "R7");
    end
    // R5 near-miss words: one opcode bit flipped
    for (int b = 20; b < 32; b++)
      drive(1, reg_word(5'd1, 5'd2, 5'd3, 5'd4) ^ (32'd1 << b),
            rnd256(), rnd256(), rnd256(), rnd256(), "R5");
    drive(1, imm_word(8'hFF, 5'd1, 5'd2) ^ 32'h0004_0000,
          rnd256(), rnd256(), rnd256(), rnd256(), "R5");
    drive(1, 32'h0, rnd256(), rnd256(), rnd256(), rnd256(), "R5");
    // R6 valid low with decodable words present
    drive(0, reg_word(5'd3, 5'd3, 5'd3, 5'd3), rnd256(), rnd256(), rnd256(), rnd256(), "R6");
    drive(0, imm_word(8'h11, 5'd5, 5'd6), rnd256(), rnd256(), rnd256(), rnd256(), "R6");
    drive(1, reg_word(5'd9, 5'd10, 5'd11, 5'd12), rnd256(), rnd256(), rnd256(), rnd256(), "R7");
    drive(0, 32'h0, '0, '0, '0, '0, "R6");

    @(negedge clk); instr_valid = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    report();
  end
endmodule